// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Controller

This block sits between a synchronous request port and an external asynchronous static RAM built from four independent 8-bit banks. Each bank has its own active-low select. The banks share one write strobe and one output-enable strobe. A request carries an address, a direction, write data and a 4-bit lane mask. The mask picks which banks take part, so a single access can be 8, 16 or 32 bits wide. The controller turns the access times of the memory, given in nanoseconds, into clock-cycle counts by rounding up. It then steps through the strobe phases with a down counter.

The memory data bus is a tristate bus. The controller does not drive it through an inout pin. Instead it presents separate output data, a per-lane output enable and input data, so the pad ring can build the tristate buffers. The controller never enables its drivers while the memory may still be driving the bus.

The request side uses a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so a requester holds its request until the controller is free. Once a request has been taken, the request inputs are ignored until the next transfer. The response is a single-cycle `rsp_valid` pulse and cannot be held off. A requester must be able to take it in any cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, all four selects, the write strobe and the output enable are high (inactive), no lane output enable is set, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only in the idle state. For a request with a nonzero mask, `req_ready` stays 0 from the cycle after acceptance until the response. Request inputs that change while the controller is busy have no effect on the access in progress.
- R3: During a read, the select of lane i (mask bit i, data bits 8i+7..8i) is low exactly when mask bit i is 1. The output enable is low and the write strobe is high. The address equals the accepted address. The output enable stays low for 3 cycles at the default timing (the largest of the cycle, address and select access times, each rounded up to 8 ns cycles). The write strobe and the output enable are never low together.
- R4: The read response returns the memory data on the enabled lanes, as sampled in the last output-enable cycle, and zero on the disabled lanes. `rsp_valid` is high for exactly one cycle.
- R5: When the output enable rises at the end of a read, all selects are already high. They stay high for one turn-off cycle before the response.
- R6: During a write, the selected lanes' selects are low and the output enable stays high. The write strobe is low for 3 consecutive cycles at the default timing: the largest of the rounded-up pulse width, the rounded-up select-to-end time, and one turn-off cycle plus the rounded-up data setup.
- R7: Write data is driven only on enabled lanes. No lane is driven in the first write-strobe cycle. Data is driven for at least the final 2 strobe cycles, and stays driven in the cycle in which the strobe rises.
- R8: No lane output enable is set while the memory output enable is low. All lane output enables are clear in the cycle before the memory output enable falls.
- R9: A request with an all-zero mask asserts no select and no strobe, changes no memory contents, and is answered with `rsp_valid` in the cycle after acceptance.
- R10: For a nonzero mask, `rsp_valid` is high in the fifth cycle after the accepting edge, for both reads and writes, at the default timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request may transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_mask | input | 4 | Lane enable, bit i selects bits 8i+7..8i |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 4 | Per-lane bank select, active low |
| mem_we_n | output | 1 | Shared write strobe, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dq_out | output | 32 | Data toward memory |
| mem_dq_oe | output | 4 | Per-lane driver enable for mem_dq_out |
| mem_dq_in | input | 32 | Data from the memory bus |

## Verification
The bench runs all sixteen lane masks, each at two addresses. Every write is read back twice, once at full width and once with the same mask. The full-width read exposes partial-write merging and lane swaps, and shows that a zero-mask write left memory untouched. The same-mask read exposes missing zeroing of disabled lanes. A memory model with per-lane selects measures each strobe length and the data-drive window in cycles, and flags any cycle in which both sides drive a lane. The request inputs are inverted right after every acceptance, which separates a design that holds the accepted request from one that follows its inputs.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RREC, ST_WR, ST_WREC
  } seq_state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] cnt,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign last = (cnt == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int CW       = 2,
  parameter int RD_CYC   = 3,
  parameter int HZ_CYC   = 1,
  parameter int WP_CYC   = 3,
  parameter int WREC_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic          req_zero,
  input  logic          cnt_last,
  output seq_state_e    state,
  output logic          ld,
  output logic [CW-1:0] ld_val,
  output logic          capture,
  output logic          done
);
  seq_state_e nxt;

  always_comb begin
    nxt     = state;
    ld      = 1'b0;
    ld_val  = '0;
    capture = 1'b0;
    done    = 1'b0;
    unique case (state)
      ST_IDLE: if (accept && !req_zero) begin
        ld     = 1'b1;
        nxt    = req_write ? ST_WR : ST_RD;
        ld_val = req_write ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
      end
      ST_RD: if (cnt_last) begin
        capture = 1'b1;
        ld      = 1'b1;
        ld_val  = CW'(HZ_CYC - 1);
        nxt     = ST_RREC;
      end
      ST_WR: if (cnt_last) begin
        ld     = 1'b1;
        ld_val = CW'(WREC_CYC - 1);
        nxt    = ST_WREC;
      end
      ST_RREC, ST_WREC: if (cnt_last) begin
        done = 1'b1;
        nxt  = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [LANES-1:0] mask_in,
  input  logic [DW-1:0]    wdata_in,
  input  logic             drive,
  input  logic             capture,
  input  logic             clear_rd,
  input  logic [DW-1:0]    din,
  output logic [LANES-1:0] mask_q,
  output logic [DW-1:0]    dq_out,
  output logic [LANES-1:0] dq_oe,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      mask_q  <= mask_in;
      wdata_q <= wdata_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_out[g*LANE_W +: LANE_W] = wdata_q[g*LANE_W +: LANE_W];
    assign dq_oe[g] = drive & mask_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n || clear_rd)
        rdata[g*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rdata[g*LANE_W +: LANE_W] <= mask_q[g] ? din[g*LANE_W +: LANE_W] : '0;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int CLK_NS   = 8,
  parameter int T_RC_NS  = 20,
  parameter int T_AA_NS  = 20,
  parameter int T_ACS_NS = 20,
  parameter int T_WC_NS  = 20,
  parameter int T_WP_NS  = 15,
  parameter int T_CW_NS  = 15,
  parameter int T_DW_NS  = 9,
  parameter int T_HZ_NS  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LANES-1:0]         req_mask,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  output logic                     rsp_valid,
  output logic [LANES*LANE_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES-1:0]         mem_cs_n,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic [LANES-1:0]         mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in
);
  localparam int RD_CYC   = imax(imax(cdiv(T_RC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS)),
                                 imax(cdiv(T_ACS_NS, CLK_NS), 1));
  localparam int HZ_CYC   = imax(cdiv(T_HZ_NS, CLK_NS), 1);
  localparam int WP_CYC   = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_CW_NS, CLK_NS)),
                                 HZ_CYC + imax(cdiv(T_DW_NS, CLK_NS), 1));
  localparam int WREC_CYC = imax(cdiv(T_WC_NS, CLK_NS) - WP_CYC, 1);
  localparam int MAX_CYC  = imax(imax(RD_CYC, HZ_CYC), imax(WP_CYC, WREC_CYC));
  localparam int CW       = imax($clog2(MAX_CYC + 1), 1);
  localparam logic [CW-1:0] DRV_AT = CW'(WP_CYC - 1 - HZ_CYC);

  seq_state_e       state;
  logic             accept, req_zero, ld, capture, done, cnt_last, drive;
  logic [CW-1:0]    ld_val, cnt;
  logic [LANES-1:0] mask_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_zero  = (req_mask == '0);

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .cnt(cnt), .last(cnt_last)
  );

  sram_seq_fsm #(
    .CW(CW), .RD_CYC(RD_CYC), .HZ_CYC(HZ_CYC), .WP_CYC(WP_CYC), .WREC_CYC(WREC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_zero(req_zero), .cnt_last(cnt_last), .state(state), .ld(ld),
    .ld_val(ld_val), .capture(capture), .done(done)
  );

  assign drive = ((state == ST_WR) && (cnt <= DRV_AT)) || (state == ST_WREC);

  sram_lane_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .mask_in(req_mask),
    .wdata_in(req_wdata), .drive(drive), .capture(capture),
    .clear_rd(accept && req_zero && !req_write), .din(mem_dq_in),
    .mask_q(mask_q), .dq_out(mem_dq_out), .dq_oe(mem_dq_oe), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (accept) mem_addr <= req_addr;
      rsp_valid <= done || (accept && req_zero);
    end
  end

  always_comb begin
    mem_cs_n = '1;
    if (state == ST_RD || state == ST_WR || state == ST_WREC) mem_cs_n = ~mask_q;
  end
  assign mem_we_n = (state != ST_WR);
  assign mem_oe_n = (state != ST_RD);
endmodule

// File: rtl/sram_lane_ctrl_checker.sv
module sram_lane_ctrl_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_mask,
  input logic [LANES-1:0] mem_cs_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic [LANES-1:0] mem_dq_oe
);
  a_r8_no_drive_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_dq_oe == '0));

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  a_r9_zero_mask_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == '0) |=> (&mem_cs_n && mem_we_n && mem_oe_n));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask != '0) |=> !req_ready);

  a_r7_drive_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe & mem_cs_n) == '0);

  a_r5_select_off_at_oe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> &mem_cs_n);

  a_r6_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_cs_n != '1));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_checker #(.LANES(LANES)) u_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mask(req_mask), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [3:0]  req_mask = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, mem_we_n, mem_oe_n;
  logic [31:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;
  logic [3:0]  mem_cs_n, mem_dq_oe;

  int checks = 0, errors = 0, cyc = 0;
  bit done_run = 0, mon_on = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_mask(req_mask),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  logic [7:0] mem [16][4];
  logic [7:0] shadow [16][4];
  logic [3:0] model_drv;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      model_drv[i] = !mem_cs_n[i] && !mem_oe_n && mem_we_n;
      mem_dq_in[i*8 +: 8] = model_drv[i] ? mem[mem_addr[3:0]][i] : 8'hEE;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [3:0]  cur_mask;
  logic [18:0] cur_addr;
  logic [7:0]  pend [4];
  logic        prev_we_n = 1, prev_oe_n = 1;
  logic [3:0]  prev_oe_lanes = 0;
  int we_run = 0, drv_run = 0, oe_run = 0;

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk((model_drv & mem_dq_oe) == 0, "R8 bus contention", {28'd0, mem_dq_oe}, {28'd0, model_drv});
      if (!mem_oe_n && !mem_we_n) chk(0, "R3 strobes together", 0, 1);
      if (mem_cs_n != 4'hF) begin
        chk(~mem_cs_n == cur_mask, "R3/R6/R9 select lanes", {28'd0, ~mem_cs_n}, {28'd0, cur_mask});
        chk(mem_addr == cur_addr, "R2/R3 address held", {13'd0, mem_addr}, {13'd0, cur_addr});
      end
      if (!mem_we_n) begin
        we_run++;
        if (mem_dq_oe != 0) drv_run++;
        if (we_run == 1) chk(mem_dq_oe == 0, "R7 no drive in first strobe cycle", {28'd0, mem_dq_oe}, 0);
        if (!mem_oe_n) chk(0, "R6 oe low during write", 0, 1);
        for (int i = 0; i < 4; i++)
          if (!mem_cs_n[i] && mem_dq_oe[i]) pend[i] = mem_dq_out[i*8 +: 8];
      end else if (!prev_we_n) begin
        chk(we_run == 3, "R6 strobe length", we_run, 3);
        chk(drv_run >= 2, "R7 data setup cycles", drv_run, 2);
        chk(mem_dq_oe == cur_mask, "R7 drive held at strobe rise", {28'd0, mem_dq_oe}, {28'd0, cur_mask});
        for (int i = 0; i < 4; i++) if (cur_mask[i]) mem[cur_addr[3:0]][i] = pend[i];
        we_run = 0; drv_run = 0;
      end
      if (!mem_oe_n) begin
        if (prev_oe_n) chk(prev_oe_lanes == 0 && mem_dq_oe == 0, "R8 release before oe", {28'd0, prev_oe_lanes}, 0);
        oe_run++;
      end else if (!prev_oe_n) begin
        chk(oe_run == 3, "R3 oe length", oe_run, 3);
        chk(&mem_cs_n, "R5 selects off at oe rise", {28'd0, mem_cs_n}, 32'hF);
        oe_run = 0;
      end
      prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_oe_lanes = mem_dq_oe;
    end
  end

  task automatic do_req(input logic wr, input logic [18:0] a, input logic [3:0] m,
                        input logic [31:0] wd, input logic [31:0] exp_rd);
    int n;
    bit busy_bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_mask = m; cur_addr = a;
    req_valid = 1; req_write = wr; req_addr = a; req_mask = m; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_write = ~wr; req_addr = ~a; req_mask = ~m; req_wdata = ~wd;
    n = 1; busy_bad = 0;
    while (!rsp_valid && n < 20) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      n++;
    end
    if (m == 0) chk(n == 1, "R9 zero-mask latency", n, 1);
    else begin
      chk(n == 5, "R10 response latency", n, 5);
      chk(!busy_bad, "R2 ready low while busy", busy_bad, 0);
    end
    if (!wr) chk(rsp_rdata == exp_rd, "R4 read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_valid, "R4 single-cycle response", rsp_valid, 0);
  endtask

  function automatic logic [31:0] expect_rd(input int a, input logic [3:0] m);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*8 +: 8] = shadow[a][i];
    return r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done_run) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 16; a++)
      for (int i = 0; i < 4; i++) begin
        mem[a][i]    = 8'((a * 37 + i * 11 + 5) & 255);
        shadow[a][i] = 8'((a * 37 + i * 11 + 5) & 255);
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n, "R1 strobes idle", {26'd0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h3F);
    chk(mem_dq_oe == 0 && !rsp_valid && req_ready, "R1 handshake idle", {26'd0, mem_dq_oe, rsp_valid, req_ready}, 32'h1);
    mon_on = 1;
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 2; k++) begin
        int a = (k == 0) ? m : 15 - m;
        logic [18:0] fa = {15'(19'h2A5C + m * 3), 4'(a)};
        logic [31:0] wd = 32'h9E3779B9 * (m * 16 + a + 1);
        do_req(1'b1, fa, 4'(m), wd, 0);
        for (int i = 0; i < 4; i++) if (m[i]) shadow[a][i] = wd[i*8 +: 8];
        do_req(1'b0, fa, 4'hF, 0, expect_rd(a, 4'hF));
        do_req(1'b0, fa, 4'(m), 0, expect_rd(a, 4'(m)));
      end
    end
    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule